// File: doc/BRIEF.md
# Versioned Object Lock Table with Read-Set Commit Validation

This block holds one metadata word for each of a small, fixed set of shared objects. Each word is in one of two states. When it is free, it carries the object's current version stamp. When it is held, it records the transaction that owns it and keeps the stamp the object had when the lock was taken.

A writing transaction claims an object through the acquire port and gives it back through the release port. A release after a committed update advances the stamp; a release after an abort leaves it unchanged. A reading transaction takes no lock. It samples the stamp, the holder and the global wrap epoch through the combinational lookup port, and software keeps these as a read-set entry.

At commit time, software opens a session on the commit port and streams its read-set entries one per cycle. The block checks each entry against the live table and reports a single pass or fail verdict one cycle after the last entry. The commit port never alters the table, so a failed validation leaves every lock in place for the owner to release.

Top module: `verlock_validator`

## Requirements
- R1: After synchronous reset every object is free with version 0, and `cur_epoch` is 0.
- R2: An acquire on an object that is free, or that the requesting transaction already holds, raises `acq_grant` (with `acq_busy` low) in the cycle after the request; the object then reads back as locked with `look_owner` equal to the requester.
- R3: An acquire on an object held by a different transaction, or on an object that the release port names in the same cycle, raises `acq_busy` (with `acq_grant` low) in the cycle after the request and leaves the table unchanged.
- R4: A release by the current holder frees the object. With `rel_bump`=1 the version rises by one; with `rel_bump`=0 it is unchanged. A release by a non-holder, or of a free object, has no effect.
- R5: The lookup outputs reflect the addressed object's word combinationally, in the same cycle.
- R6: A read-set entry fails when its version differs from the object's current version.
- R7: A read-set entry fails when its `cm_seen_busy` flag is 1 (the object was held by another transaction when it was read), or when the object is held by a transaction other than the committer at commit time.
- R8: An entry for an object held by the committing transaction passes when its version equals the version kept in the held word.
- R9: A bumping release from version 2^VER_W-1 wraps the version to 0 and increments `cur_epoch`. An entry whose `cm_epoch` differs from `cur_epoch` fails.
- R10: `cm_done` pulses for one cycle, in the cycle after the entry marked `cm_last`. `cm_pass` is 1 only if every entry of the session passed; one failing entry fails the whole session.
- R11: Commit sessions never change any lock, owner or version, whether they pass or fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_valid | input | 1 | Acquire request strobe |
| acq_obj | input | 3 | Object to lock |
| acq_tx | input | 4 | Requesting transaction ID |
| acq_grant | output | 1 | Previous-cycle acquire succeeded |
| acq_busy | output | 1 | Previous-cycle acquire refused |
| rel_valid | input | 1 | Release request strobe |
| rel_obj | input | 3 | Object to release |
| rel_tx | input | 4 | Releasing transaction ID |
| rel_bump | input | 1 | 1 = committed update, advance version |
| look_obj | input | 3 | Object to inspect |
| look_locked | output | 1 | Inspected object is held |
| look_owner | output | 4 | Holder of inspected object |
| look_ver | output | 8 | Version of inspected object |
| cur_epoch | output | 4 | Count of version wraps |
| cm_start | input | 1 | Open a commit session |
| cm_tx | input | 4 | Committing transaction ID |
| cm_valid | input | 1 | Read-set entry strobe |
| cm_obj | input | 3 | Entry object |
| cm_ver | input | 8 | Entry recorded version |
| cm_epoch | input | 4 | Entry recorded epoch |
| cm_seen_busy | input | 1 | Entry object was held by another at read time |
| cm_last | input | 1 | Entry is the final one |
| cm_active | output | 1 | A session is open |
| cm_done | output | 1 | Verdict strobe |
| cm_pass | output | 1 | Verdict: all entries passed |

## Verification
The assertions assume that read-set entries arrive only after `cm_start` has opened a session, one entry per cycle, and that each session ends with exactly one entry marked `cm_last`. They also assume that acquire and release identifiers stay within the object count. The bench drives every request on the falling edge with these strobes held for exactly one cycle. It never overlaps two sessions and only ever names objects that exist, so the checked properties stay inside that envelope. The one deliberate same-cycle collision, an acquire and a release on the same object, is a case the design defines (R3).

// File: rtl/vlk_pkg.sv
package vlk_pkg;
    localparam int VER_W = 8;
    localparam int TX_W  = 4;
    localparam int EP_W  = 4;

    typedef logic [VER_W-1:0] ver_t;
    typedef logic [TX_W-1:0]  tx_t;
    typedef logic [EP_W-1:0]  ep_t;

    typedef struct packed {
        logic locked;
        tx_t  owner;
        ver_t ver;
    } meta_t;

    typedef enum logic [0:0] {V_IDLE, V_WALK} vstate_e;

    localparam ver_t VER_MAX = {VER_W{1'b1}};

    // True when a read-set entry must be rejected.
    function automatic logic entry_bad(input meta_t m, input tx_t who,
                                       input ver_t seen_ver, input logic seen_busy,
                                       input logic epoch_ok);
        logic bad;
        bad = seen_busy || !epoch_ok;
        if (m.locked)
            bad = bad || (m.owner != who) || (m.ver != seen_ver);
        else
            bad = bad || (m.ver != seen_ver);
        return bad;
    endfunction
endpackage

// File: rtl/vlk_acq_dec.sv
module vlk_acq_dec
    import vlk_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int OBJ_W = $clog2(NUM_OBJ)
) (
    input  meta_t            meta [NUM_OBJ],
    input  logic [OBJ_W-1:0] acq_obj,
    input  tx_t              acq_tx,
    input  logic             rel_valid,
    input  logic [OBJ_W-1:0] rel_obj,
    output logic             acq_ok
);
    meta_t cur;
    logic  collide;

    always_comb begin
        cur     = meta[acq_obj];
        collide = rel_valid && (rel_obj == acq_obj);
        acq_ok  = (!cur.locked || (cur.owner == acq_tx)) && !collide;
    end
endmodule

// File: rtl/vlk_table.sv
module vlk_table
    import vlk_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int OBJ_W = $clog2(NUM_OBJ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_valid,
    input  logic [OBJ_W-1:0] acq_obj,
    input  tx_t              acq_tx,
    input  logic             acq_ok,
    input  logic             rel_valid,
    input  logic [OBJ_W-1:0] rel_obj,
    input  tx_t              rel_tx,
    input  logic             rel_bump,
    output meta_t            meta [NUM_OBJ],
    output ep_t              epoch,
    output logic             acq_grant,
    output logic             acq_busy
);
    logic [NUM_OBJ-1:0] rel_hit;
    logic [NUM_OBJ-1:0] acq_hit;
    logic               wrap_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_grant <= 1'b0;
            acq_busy  <= 1'b0;
        end else begin
            acq_grant <= acq_valid && acq_ok;
            acq_busy  <= acq_valid && !acq_ok;
        end
    end

    always_comb begin
        wrap_now = 1'b0;
        for (int k = 0; k < NUM_OBJ; k++)
            if (rel_hit[k] && rel_bump && meta[k].ver == VER_MAX)
                wrap_now = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           epoch <= '0;
        else if (wrap_now) epoch <= epoch + 1'b1;
    end

    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
        assign rel_hit[i] = rel_valid && (rel_obj == OBJ_W'(i)) &&
                            meta[i].locked && (meta[i].owner == rel_tx);
        assign acq_hit[i] = acq_valid && acq_ok && (acq_obj == OBJ_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= '0;
            end else if (rel_hit[i]) begin
                meta[i].locked <= 1'b0;
                if (rel_bump) meta[i].ver <= meta[i].ver + 1'b1;
            end else if (acq_hit[i]) begin
                meta[i].locked <= 1'b1;
                meta[i].owner  <= acq_tx;
            end
        end

        // R3
        lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (meta[i].locked && !(rel_valid && rel_obj == OBJ_W'(i) && rel_tx == meta[i].owner))
            |=> (meta[i].locked && meta[i].owner == $past(meta[i].owner)));

        // R4
        ver_step_chk: assert property (@(posedge clk) disable iff (rst)
            (rel_hit[i] && rel_bump) |=> (meta[i].ver == ver_t'($past(meta[i].ver) + 1'b1)));

        // R11
        ver_still_chk: assert property (@(posedge clk) disable iff (rst)
            !(rel_valid && rel_obj == OBJ_W'(i)) |=> $stable(meta[i].ver));
    end

    // R2
    grant_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (acq_valid && acq_ok) |=> (meta[$past(acq_obj)].locked &&
                                   meta[$past(acq_obj)].owner == $past(acq_tx)));

    // R3
    grant_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(acq_grant && acq_busy));

    // R9
    epoch_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(epoch) |-> $past(wrap_now));
endmodule

// File: rtl/vlk_validator.sv
module vlk_validator
    import vlk_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int OBJ_W = $clog2(NUM_OBJ)
) (
    input  logic             clk,
    input  logic             rst,
    input  meta_t            meta [NUM_OBJ],
    input  ep_t              epoch,
    input  logic             cm_start,
    input  tx_t              cm_tx,
    input  logic             cm_valid,
    input  logic [OBJ_W-1:0] cm_obj,
    input  ver_t             cm_ver,
    input  ep_t              cm_epoch,
    input  logic             cm_seen_busy,
    input  logic             cm_last,
    output logic             cm_active,
    output logic             cm_done,
    output logic             cm_pass
);
    vstate_e st;
    tx_t     tx_q;
    logic    fail_q;
    logic    ent_bad;
    logic    take;

    assign take = (st == V_WALK) && cm_valid;

    always_comb
        ent_bad = entry_bad(meta[cm_obj], tx_q, cm_ver, cm_seen_busy, cm_epoch == epoch);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= V_IDLE;
            tx_q    <= '0;
            fail_q  <= 1'b0;
            cm_done <= 1'b0;
            cm_pass <= 1'b0;
        end else begin
            cm_done <= 1'b0;
            cm_pass <= 1'b0;
            if (cm_start) begin
                st     <= V_WALK;
                tx_q   <= cm_tx;
                fail_q <= 1'b0;
            end else if (take) begin
                fail_q <= fail_q || ent_bad;
                if (cm_last) begin
                    st      <= V_IDLE;
                    cm_done <= 1'b1;
                    cm_pass <= !(fail_q || ent_bad);
                end
            end
        end
    end

    assign cm_active = (st == V_WALK);

    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        cm_done |-> $past(cm_valid && cm_last && cm_active));

    // R10
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        cm_pass |-> cm_done);

    // R10
    sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (take && ent_bad && !cm_last) |=> (cm_active && fail_q));
endmodule

// File: rtl/verlock_validator.sv
module verlock_validator
    import vlk_pkg::*;
#(
    parameter int NUM_OBJ = 8,
    localparam int OBJ_W = $clog2(NUM_OBJ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_valid,
    input  logic [OBJ_W-1:0] acq_obj,
    input  logic [TX_W-1:0]  acq_tx,
    output logic             acq_grant,
    output logic             acq_busy,
    input  logic             rel_valid,
    input  logic [OBJ_W-1:0] rel_obj,
    input  logic [TX_W-1:0]  rel_tx,
    input  logic             rel_bump,
    input  logic [OBJ_W-1:0] look_obj,
    output logic             look_locked,
    output logic [TX_W-1:0]  look_owner,
    output logic [VER_W-1:0] look_ver,
    output logic [EP_W-1:0]  cur_epoch,
    input  logic             cm_start,
    input  logic [TX_W-1:0]  cm_tx,
    input  logic             cm_valid,
    input  logic [OBJ_W-1:0] cm_obj,
    input  logic [VER_W-1:0] cm_ver,
    input  logic [EP_W-1:0]  cm_epoch,
    input  logic             cm_seen_busy,
    input  logic             cm_last,
    output logic             cm_active,
    output logic             cm_done,
    output logic             cm_pass
);
    meta_t meta [NUM_OBJ];
    logic  acq_ok;
    ep_t   epoch;
    meta_t seen;

    vlk_acq_dec #(.NUM_OBJ(NUM_OBJ)) u_dec (
        .meta(meta), .acq_obj(acq_obj), .acq_tx(acq_tx),
        .rel_valid(rel_valid), .rel_obj(rel_obj), .acq_ok(acq_ok)
    );

    vlk_table #(.NUM_OBJ(NUM_OBJ)) u_tbl (
        .clk(clk), .rst(rst),
        .acq_valid(acq_valid), .acq_obj(acq_obj), .acq_tx(acq_tx), .acq_ok(acq_ok),
        .rel_valid(rel_valid), .rel_obj(rel_obj), .rel_tx(rel_tx), .rel_bump(rel_bump),
        .meta(meta), .epoch(epoch), .acq_grant(acq_grant), .acq_busy(acq_busy)
    );

    vlk_validator #(.NUM_OBJ(NUM_OBJ)) u_val (
        .clk(clk), .rst(rst), .meta(meta), .epoch(epoch),
        .cm_start(cm_start), .cm_tx(cm_tx), .cm_valid(cm_valid), .cm_obj(cm_obj),
        .cm_ver(cm_ver), .cm_epoch(cm_epoch), .cm_seen_busy(cm_seen_busy),
        .cm_last(cm_last), .cm_active(cm_active), .cm_done(cm_done), .cm_pass(cm_pass)
    );

    always_comb begin
        seen        = meta[look_obj];
        look_locked = seen.locked;
        look_owner  = seen.owner;
        look_ver    = seen.ver;
    end

    assign cur_epoch = epoch;

    // R1
    reset_epoch_chk: assert property (@(posedge clk)
        $past(rst) |-> (cur_epoch == '0));
endmodule

// File: tb/sim_verlock_validator.sv
module sim_verlock_validator;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq_valid = 0, rel_valid = 0, rel_bump = 0;
    logic [2:0] acq_obj = 0, rel_obj = 0, look_obj = 0, cm_obj = 0;
    logic [3:0] acq_tx = 0, rel_tx = 0, cm_tx = 0, cm_epoch = 0;
    logic [7:0] cm_ver = 0;
    logic       cm_start = 0, cm_valid = 0, cm_seen_busy = 0, cm_last = 0;
    logic       acq_grant, acq_busy, look_locked, cm_active, cm_done, cm_pass;
    logic [3:0] look_owner, cur_epoch;
    logic [7:0] look_ver;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    verlock_validator u0 (
        .clk(clk), .rst(rst),
        .acq_valid(acq_valid), .acq_obj(acq_obj), .acq_tx(acq_tx),
        .acq_grant(acq_grant), .acq_busy(acq_busy),
        .rel_valid(rel_valid), .rel_obj(rel_obj), .rel_tx(rel_tx), .rel_bump(rel_bump),
        .look_obj(look_obj), .look_locked(look_locked), .look_owner(look_owner),
        .look_ver(look_ver), .cur_epoch(cur_epoch),
        .cm_start(cm_start), .cm_tx(cm_tx), .cm_valid(cm_valid), .cm_obj(cm_obj),
        .cm_ver(cm_ver), .cm_epoch(cm_epoch), .cm_seen_busy(cm_seen_busy),
        .cm_last(cm_last), .cm_active(cm_active), .cm_done(cm_done), .cm_pass(cm_pass)
    );

    // Vector fields: op[19:17] obj[16:14] tx[13:10] ver[9:2] exp[1:0]
    // op 0 acquire (exp 1 grant / 0 busy), 1 release, 2 bumping release,
    // 3 single-entry commit (exp 1 pass), 4 lookup (exp bit0 = locked, ver = version)
    localparam int NV = 17;
    localparam logic [19:0] VEC [NV] = '{
        {3'd4, 3'd0, 4'd0, 8'd0, 2'd0},
        {3'd0, 3'd0, 4'd1, 8'd0, 2'd1},
        {3'd0, 3'd0, 4'd2, 8'd0, 2'd0},
        {3'd0, 3'd0, 4'd1, 8'd0, 2'd1},
        {3'd3, 3'd0, 4'd2, 8'd0, 2'd0},
        {3'd3, 3'd0, 4'd1, 8'd0, 2'd1},
        {3'd2, 3'd0, 4'd2, 8'd0, 2'd0},
        {3'd4, 3'd0, 4'd0, 8'd0, 2'd1},
        {3'd2, 3'd0, 4'd1, 8'd0, 2'd0},
        {3'd4, 3'd0, 4'd0, 8'd1, 2'd0},
        {3'd3, 3'd0, 4'd2, 8'd0, 2'd0},
        {3'd3, 3'd0, 4'd2, 8'd1, 2'd1},
        {3'd0, 3'd3, 4'd2, 8'd0, 2'd1},
        {3'd1, 3'd3, 4'd2, 8'd0, 2'd0},
        {3'd4, 3'd3, 4'd0, 8'd0, 2'd0},
        {3'd1, 3'd3, 4'd2, 8'd0, 2'd0},
        {3'd4, 3'd3, 4'd0, 8'd0, 2'd0}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_acq(input logic [2:0] o, input logic [3:0] t, input logic exp, input string tag);
        @(negedge clk);
        acq_valid = 1; acq_obj = o; acq_tx = t;
        @(negedge clk);
        acq_valid = 0;
        chk(acq_grant == exp && acq_busy == !exp, tag, {acq_grant, acq_busy}, {exp, !exp});
    endtask

    task automatic do_rel(input logic [2:0] o, input logic [3:0] t, input logic b);
        @(negedge clk);
        rel_valid = 1; rel_obj = o; rel_tx = t; rel_bump = b;
        @(negedge clk);
        rel_valid = 0; rel_bump = 0;
    endtask

    task automatic look_chk(input logic [2:0] o, input logic lk, input logic [7:0] v, input string tag);
        @(negedge clk);
        look_obj = o;
        #1;
        chk(look_locked == lk && look_ver == v, tag, {look_locked, look_ver}, {lk, v});
    endtask

    task automatic cm_begin(input logic [3:0] t);
        @(negedge clk);
        cm_start = 1; cm_tx = t;
    endtask

    task automatic cm_ent(input logic [2:0] o, input logic [7:0] v, input logic [3:0] ep,
                          input logic sb, input logic last);
        @(negedge clk);
        cm_start = 0;
        cm_valid = 1; cm_obj = o; cm_ver = v; cm_epoch = ep; cm_seen_busy = sb; cm_last = last;
    endtask

    task automatic cm_finish(input logic exp, input string tag);
        @(negedge clk);
        cm_valid = 0; cm_last = 0; cm_seen_busy = 0;
        chk(cm_done == 1'b1 && cm_pass == exp, tag, {cm_done, cm_pass}, {1'b1, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        for (int i = 0; i < 8; i++) look_chk(3'(i), 1'b0, 8'd0, "R1");
        chk(cur_epoch == 0, "R1 epoch", cur_epoch, 0);
        chk(acq_grant == 0 && acq_busy == 0 && cm_done == 0, "R1 outputs", {acq_grant, acq_busy, cm_done}, 0);

        for (int n = 0; n < NV; n++) begin
            logic [2:0] op, o;
            logic [3:0] t;
            logic [7:0] v;
            logic [1:0] e;
            {op, o, t, v, e} = VEC[n];
            case (op)
                3'd0: do_acq(o, t, e[0], e[0] ? "R2 vector" : "R3 vector");
                3'd1: do_rel(o, t, 1'b0);
                3'd2: do_rel(o, t, 1'b1);
                3'd3: begin
                    cm_begin(t);
                    cm_ent(o, v, 4'd0, 1'b0, 1'b1);
                    cm_finish(e[0], "R6 R7 R8 vector");
                end
                default: look_chk(o, e[0], v, "R4 R5 vector");
            endcase
        end

        // R2 owner visible through lookup
        do_acq(3'd4, 4'd7, 1'b1, "R2 acquire");
        @(negedge clk); look_obj = 3'd4; #1;
        chk(look_owner == 4'd7 && look_locked, "R2 owner", look_owner, 7);
        do_rel(3'd4, 4'd7, 1'b0);

        // R7 entry flagged as held by another at read time
        cm_begin(4'd3);
        cm_ent(3'd1, 8'd0, 4'd0, 1'b1, 1'b1);
        cm_finish(1'b0, "R7 seen busy");

        // R10 R11 multi-entry session with one bad entry in the middle
        do_acq(3'd6, 4'd1, 1'b1, "R2 obj6");
        cm_begin(4'd1);
        cm_ent(3'd1, 8'd0, 4'd0, 1'b0, 1'b0);
        cm_ent(3'd4, 8'd9, 4'd0, 1'b0, 1'b0);
        cm_ent(3'd6, 8'd0, 4'd0, 1'b0, 1'b1);
        cm_finish(1'b0, "R10 sticky fail");
        @(negedge clk); look_obj = 3'd6; #1;
        chk(look_locked && look_owner == 4'd1, "R11 lock kept", {look_locked, look_owner}, {1'b1, 4'd1});
        do_acq(3'd6, 4'd2, 1'b0, "R11 still held");
        cm_begin(4'd1);
        cm_ent(3'd1, 8'd0, 4'd0, 1'b0, 1'b0);
        cm_ent(3'd6, 8'd0, 4'd0, 1'b0, 1'b1);
        cm_finish(1'b1, "R10 all pass");
        @(negedge clk);
        chk(cm_done == 0, "R10 single pulse", cm_done, 0);
        do_rel(3'd6, 4'd1, 1'b0);

        // R3 acquire colliding with release of the same object
        do_acq(3'd2, 4'd1, 1'b1, "R2 obj2");
        @(negedge clk);
        acq_valid = 1; acq_obj = 3'd2; acq_tx = 4'd1;
        rel_valid = 1; rel_obj = 3'd2; rel_tx = 4'd1; rel_bump = 1;
        @(negedge clk);
        acq_valid = 0; rel_valid = 0; rel_bump = 0;
        chk(acq_busy && !acq_grant, "R3 collide", {acq_grant, acq_busy}, 1);
        look_chk(3'd2, 1'b0, 8'd1, "R3 collide table");

        // R9 wrap of version and epoch
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            acq_valid = 1; acq_obj = 3'd5; acq_tx = 4'd4;
            @(negedge clk);
            acq_valid = 0;
            rel_valid = 1; rel_obj = 3'd5; rel_tx = 4'd4; rel_bump = 1;
            @(negedge clk);
            rel_valid = 0; rel_bump = 0;
        end
        look_chk(3'd5, 1'b0, 8'd0, "R9 wrap version");
        chk(cur_epoch == 4'd1, "R9 epoch", cur_epoch, 1);
        cm_begin(4'd2);
        cm_ent(3'd5, 8'd0, 4'd0, 1'b0, 1'b1);
        cm_finish(1'b0, "R9 old epoch");
        cm_begin(4'd2);
        cm_ent(3'd5, 8'd0, 4'd1, 1'b0, 1'b1);
        cm_finish(1'b1, "R9 new epoch");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule